// File: doc/BRIEF.md
# Receive Checksum Status Writeback

This block watches a received Ethernet frame as it streams past, one byte per accepted beat, and builds the fields of a receive completion descriptor. These fields are the reported length, a 16-bit checksum value, a status byte, an error byte and a VLAN tag field. It recognises IPv4 frames and, inside them, TCP and UDP segments. When the matching offload enable is set, it verifies the IPv4 header checksum and the TCP or UDP checksum, including the pseudo-header.

All checksums are 16-bit ones-complement sums with end-around carry. Bytes at even offsets form the high half of a word. A trailing odd byte is padded with a zero low byte. Checksum coverage always starts at offset zero of the covered region. The reported result is the ones complement of the folded sum, so a correct checksum yields zero. The descriptor appears on a one-cycle strobe after the last byte of the frame.

Top module: `rx_csum_wb`

## Requirements
- R1: `desc_len` is the number of bytes in the frame plus 4 when `cfg_strip_crc` is 0, and the byte count unchanged when it is 1.
- R2: Every descriptor has status bit 0 (done) and bit 1 (end of packet) set, and `desc_vlan` is zero.
- R3: A frame is IPv4 when bytes 12..13 hold 0x0800 and the upper nibble of byte 14 is 4. The lower nibble of byte 14 gives the header length in 32-bit words. A non-IPv4 frame gets status 0x03, errors 0x00 and checksum 0x0000 whatever the enables.
- R4: For an IPv4 frame with `cfg_ip_ofld` set, status bit 6 is set. The checksum field takes the IP header result, and error bit 6 is set when that result is nonzero.
- R5: With `cfg_l4_ofld` set, an IPv4 frame whose byte 23 is 6 (TCP) sets status bit 5, and one whose byte 23 is 17 (UDP) sets status bit 4. Any other protocol sets neither bit. A nonzero L4 result sets error bit 5 in both cases.
- R6: The L4 sum covers the source and destination addresses, the protocol byte, the L4 length (IP total length minus header length) and the L4 bytes up to the IP total length. Ethernet padding beyond the total length is ignored, and an odd final byte is padded with zero.
- R7: When an L4 check is performed, the checksum field holds the L4 result and not the IP result.
- R8: The offload enables and `cfg_strip_crc` are taken with the last byte. A disabled class produces neither its status bit nor its error bit.
- R9: `desc_valid` is high for exactly one cycle, in the cycle after the last byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte present on `in_data` |
| in_data | input | 8 | Frame byte, destination address first |
| in_last | input | 1 | Marks the final byte of a frame |
| cfg_strip_crc | input | 1 | 1: frame length reported without CRC adjustment |
| cfg_ip_ofld | input | 1 | Enable IPv4 header checksum check |
| cfg_l4_ofld | input | 1 | Enable TCP/UDP checksum check |
| desc_valid | output | 1 | One-cycle descriptor strobe |
| desc_len | output | 16 | Reported length |
| desc_csum | output | 16 | Last computed checksum result |
| desc_status | output | 8 | Status bits (0 done, 1 eop, 4 udp, 5 tcp, 6 ip) |
| desc_err | output | 8 | Error bits (5 L4, 6 IP) |
| desc_vlan | output | 16 | VLAN field, always zero |

## Verification
The assertions assume that every frame is at least 14 bytes long. They assume that an IPv4 frame carries a header length of at least 5 words, and that its frame covers the whole IP header and the total length it declares. The properties relate the strobe to a preceding last byte and tie each status and error bit to the enable sampled with that byte. The directed stimulus builds every frame from these rules, with header lengths of 5 and 6 words and totals that never exceed the frame. Where there is padding, the padding lies beyond the declared total length.

// File: rtl/rx_csum_wb.sv
module rx_csum_wb #(
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  input  logic          cfg_strip_crc,
  input  logic          cfg_ip_ofld,
  input  logic          cfg_l4_ofld,
  output logic          desc_valid,
  output logic [LW-1:0] desc_len,
  output logic [15:0]   desc_csum,
  output logic [7:0]    desc_status,
  output logic [7:0]    desc_err,
  output logic [15:0]   desc_vlan
);

  function automatic logic [15:0] oadd(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[15:0] + {15'd0, s[16]};
  endfunction

  logic [15:0] pos, etype, tlen, ip_acc, l4_acc;
  logic [7:0]  vihl, proto;
  logic [15:0] ip_base, l4_base, ip_nx, l4_nx;

  wire [15:0] word   = pos[0] ? {8'h00, in_data} : {in_data, 8'h00};
  wire [15:0] hlen   = {10'd0, vihl[3:0], 2'b00};
  wire        in_iph = (pos >= 16'd14) && ((pos < 16'd18) || (pos < 16'd14 + hlen));
  wire        in_l4  = (pos >= 16'd34) && (pos >= 16'd14 + hlen) && (pos < 16'd14 + tlen);
  wire        pseudo = (pos == 16'd23) || ((pos >= 16'd26) && (pos < 16'd34));

  always_comb begin
    ip_base = (pos == 16'd0) ? 16'd0 : ip_acc;
    l4_base = (pos == 16'd0) ? 16'd0 : l4_acc;
    ip_nx   = in_iph ? oadd(ip_base, word) : ip_base;
    l4_nx   = (in_l4 || pseudo) ? oadd(l4_base, word) : l4_base;
  end

  wire        is_ip  = (etype == 16'h0800) && (vihl[7:4] == 4'd4);
  wire        ipc    = is_ip && cfg_ip_ofld;
  wire        tc     = is_ip && (proto == 8'd6) && cfg_l4_ofld;
  wire        uc     = is_ip && (proto == 8'd17) && cfg_l4_ofld;
  wire [15:0] ip_res = ~ip_nx;
  wire [15:0] l4_res = ~oadd(l4_nx, tlen - hlen);
  wire        fin    = in_valid && in_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos    <= '0;
      etype  <= '0;
      tlen   <= '0;
      vihl   <= '0;
      proto  <= '0;
      ip_acc <= '0;
      l4_acc <= '0;
    end else if (in_valid) begin
      pos    <= in_last ? 16'd0 : pos + 16'd1;
      ip_acc <= ip_nx;
      l4_acc <= l4_nx;
      case (pos)
        16'd12: etype[15:8] <= in_data;
        16'd13: etype[7:0]  <= in_data;
        16'd14: vihl        <= in_data;
        16'd16: tlen[15:8]  <= in_data;
        16'd17: tlen[7:0]   <= in_data;
        16'd23: proto       <= in_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      desc_valid  <= 1'b0;
      desc_len    <= '0;
      desc_csum   <= '0;
      desc_status <= '0;
      desc_err    <= '0;
    end else begin
      desc_valid <= fin;
      if (fin) begin
        desc_len    <= LW'(pos) + LW'(1) + (cfg_strip_crc ? LW'(0) : LW'(4));
        desc_status <= {1'b0, ipc, tc, uc, 2'b00, 2'b11};
        desc_err    <= {1'b0, ipc && (ip_res != 16'd0), (tc || uc) && (l4_res != 16'd0), 5'd0};
        desc_csum   <= (tc || uc) ? l4_res : (ipc ? ip_res : 16'd0);
      end
    end
  end

  assign desc_vlan = 16'd0;

endmodule

module rx_csum_wb_chk #(
  parameter int LW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_last,
  input logic          cfg_strip_crc,
  input logic          cfg_ip_ofld,
  input logic          cfg_l4_ofld,
  input logic          desc_valid,
  input logic [LW-1:0] desc_len,
  input logic [15:0]   desc_csum,
  input logic [7:0]    desc_status,
  input logic [7:0]    desc_err
);

  a_r9_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> $past(in_valid && in_last));

  a_r2_done_eop: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> (desc_status[1:0] == 2'b11));

  a_r1_crc_len: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && !$past(cfg_strip_crc)) |-> (desc_len >= LW'(5)));

  a_r8_ip_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && desc_status[6]) |-> $past(cfg_ip_ofld));

  a_r8_l4_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && (desc_status[5] || desc_status[4])) |-> $past(cfg_l4_ofld));

  a_r4_ip_err_status: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && desc_err[6]) |-> desc_status[6]);

  a_r5_l4_err_status: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && desc_err[5]) |-> (desc_status[5] || desc_status[4]));

  a_r5_one_l4: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> $onehot0(desc_status[5:4]));

  a_r3_no_check_no_csum: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && (desc_status[6:4] == 3'b000)) |-> (desc_csum == 16'd0 && desc_err == 8'd0));

endmodule

bind rx_csum_wb rx_csum_wb_chk #(.LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
  .cfg_strip_crc(cfg_strip_crc), .cfg_ip_ofld(cfg_ip_ofld), .cfg_l4_ofld(cfg_l4_ofld),
  .desc_valid(desc_valid), .desc_len(desc_len), .desc_csum(desc_csum),
  .desc_status(desc_status), .desc_err(desc_err)
);

// File: tb/sim_rx_csum_wb.sv
`timescale 1ns/1ps
module sim_rx_csum_wb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = 8'd0;
  logic cfg_strip_crc = 1'b0, cfg_ip_ofld = 1'b0, cfg_l4_ofld = 1'b0;
  logic desc_valid;
  logic [15:0] desc_len, desc_csum, desc_vlan;
  logic [7:0] desc_status, desc_err;

  always #2.5 clk = ~clk;

  rx_csum_wb u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .cfg_strip_crc(cfg_strip_crc), .cfg_ip_ofld(cfg_ip_ofld), .cfg_l4_ofld(cfg_l4_ofld),
    .desc_valid(desc_valid), .desc_len(desc_len), .desc_csum(desc_csum),
    .desc_status(desc_status), .desc_err(desc_err), .desc_vlan(desc_vlan)
  );

  int n_chk = 0, n_err = 0;
  logic [7:0] fr [0:255];
  int fn, f_ihl, f_l4n, f_pr;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic int unsigned wsum(input int st, input int n);
    int unsigned s = 0;
    for (int k = 0; k < n; k++) s += (k % 2 == 0) ? {16'd0, fr[st+k], 8'd0} : {24'd0, fr[st+k]};
    return s;
  endfunction

  function automatic logic [15:0] fold(input int unsigned s);
    int unsigned t = s;
    while (t > 32'hFFFF) t = (t & 32'hFFFF) + (t >> 16);
    return t[15:0];
  endfunction

  function automatic logic [15:0] l4_model();
    int unsigned s;
    s = wsum(26, 8) + f_pr + f_l4n + wsum(14 + f_ihl*4, f_l4n);
    return ~fold(s);
  endfunction

  task automatic mk_ip(input int ihl, input int pr, input int l4n, input int pad_to,
                       input bit bad_ip, input bit bad_l4);
    int tl, l4s, co;
    logic [15:0] c;
    f_ihl = ihl; f_l4n = l4n; f_pr = pr;
    tl = ihl*4 + l4n; l4s = 14 + ihl*4;
    for (int i = 0; i < 256; i++) fr[i] = 8'hEE;
    for (int i = 0; i < 12; i++) fr[i] = 8'(8'h10 + i);
    fr[12] = 8'h08; fr[13] = 8'h00;
    fr[14] = {4'h4, 4'(ihl)}; fr[15] = 8'h00;
    fr[16] = 8'(tl >> 8); fr[17] = 8'(tl);
    fr[18] = 8'h12; fr[19] = 8'h34; fr[20] = 8'h40; fr[21] = 8'h00;
    fr[22] = 8'h40; fr[23] = 8'(pr); fr[24] = 8'h00; fr[25] = 8'h00;
    fr[26] = 8'hFF; fr[27] = 8'hFE; fr[28] = 8'h01; fr[29] = 8'h02;
    fr[30] = 8'hF0; fr[31] = 8'hFF; fr[32] = 8'h00; fr[33] = 8'h07;
    for (int i = 34; i < l4s; i++) fr[i] = 8'(8'hA0 + i);
    for (int i = 0; i < l4n; i++) fr[l4s+i] = 8'((i*37 + 5) & 255);
    co = (pr == 6) ? 16 : 6;
    if (pr == 17) begin fr[l4s+4] = 8'(l4n >> 8); fr[l4s+5] = 8'(l4n); end
    if (pr == 6 || pr == 17) begin
      fr[l4s+co] = 8'h00; fr[l4s+co+1] = 8'h00;
      c = l4_model();
      fr[l4s+co] = c[15:8]; fr[l4s+co+1] = c[7:0];
    end
    c = ~fold(wsum(14, ihl*4));
    fr[24] = c[15:8]; fr[25] = c[7:0];
    if (bad_ip) fr[21] = fr[21] ^ 8'h01;
    if (bad_l4) fr[l4s+l4n-1] = fr[l4s+l4n-1] ^ 8'h55;
    fn = (14 + tl > pad_to) ? 14 + tl : pad_to;
  endtask

  task automatic send_frame(input bit strip, input bit ipo, input bit l4o);
    for (int i = 0; i < fn; i++) begin
      in_valid = 1'b1; in_data = fr[i]; in_last = (i == fn-1);
      cfg_strip_crc = (i == fn-1) ? strip : ~strip;
      cfg_ip_ofld   = (i == fn-1) ? ipo : ~ipo;
      cfg_l4_ofld   = (i == fn-1) ? l4o : ~l4o;
      @(negedge clk);
    end
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic expect_desc(input string nm, input bit ipf, input bit strip, input bit ipo, input bit l4o);
    bit ipc, tc, uc;
    logic [15:0] ipr, l4r, ecs;
    logic [7:0] est, eer;
    ipc = ipf && ipo; tc = ipf && f_pr == 6 && l4o; uc = ipf && f_pr == 17 && l4o;
    ipr = ipf ? ~fold(wsum(14, f_ihl*4)) : 16'd0;
    l4r = ipf ? l4_model() : 16'd0;
    est = {1'b0, ipc, tc, uc, 4'b0011};
    eer = {1'b0, ipc && ipr != 0, (tc || uc) && l4r != 0, 5'd0};
    ecs = (tc || uc) ? l4r : (ipc ? ipr : 16'd0);
    chk({nm, " R9 strobe"}, 32'(desc_valid), 32'd1);
    chk({nm, " R1 length"}, 32'(desc_len), 32'(fn + (strip ? 0 : 4)));
    chk({nm, " R2/R3/R4/R5/R8 status"}, 32'(desc_status), 32'(est));
    chk({nm, " R4/R5/R8 errors"}, 32'(desc_err), 32'(eer));
    chk({nm, " R4/R6/R7 checksum"}, 32'(desc_csum), 32'(ecs));
    chk({nm, " R2 vlan"}, 32'(desc_vlan), 32'd0);
    @(negedge clk);
    chk({nm, " R9 single cycle"}, 32'(desc_valid), 32'd0);
  endtask

  task automatic t_non_ip(input bit strip);
    f_ihl = 5; f_l4n = 0; f_pr = 0;
    for (int i = 0; i < 60; i++) fr[i] = 8'((i*11 + 3) & 255);
    fr[12] = 8'h08; fr[13] = 8'h06; fr[14] = 8'h45;
    fn = 60;
    send_frame(strip, 1'b1, 1'b1);
    expect_desc("non-ip R3", 1'b0, strip, 1'b1, 1'b1);
  endtask

  task automatic t_ip(input string nm, input int ihl, input int pr, input int l4n, input int pad,
                      input bit bip, input bit bl4, input bit strip, input bit ipo, input bit l4o);
    mk_ip(ihl, pr, l4n, pad, bip, bl4);
    send_frame(strip, ipo, l4o);
    expect_desc(nm, 1'b1, strip, ipo, l4o);
  endtask

  initial begin
    #1000000;
    n_err++;
    $display("FAIL watchdog R9 actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("reset R9 strobe low", 32'(desc_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    t_non_ip(1'b0);
    t_non_ip(1'b1);
    t_ip("tcp good R5",         5, 6,  40, 0,  0, 0, 0, 1, 1);
    t_ip("tcp bad l4 R5",       5, 6,  41, 0,  0, 1, 1, 1, 1);
    t_ip("udp odd R6",          5, 17, 27, 0,  0, 0, 0, 1, 1);
    t_ip("udp bad R5",          5, 17, 12, 0,  0, 1, 0, 1, 1);
    t_ip("ip bad l4 off R4",    5, 6,  20, 0,  1, 0, 0, 1, 0);
    t_ip("both bad R7",         5, 6,  33, 0,  1, 1, 1, 1, 1);
    t_ip("ip off tcp R8",       5, 6,  24, 0,  1, 0, 0, 0, 1);
    t_ip("both off R8",         5, 17, 16, 0,  1, 1, 0, 0, 0);
    t_ip("ihl6 udp pad R6",     6, 17, 9,  60, 0, 0, 1, 1, 1);
    t_ip("ihl6 tcp bad pad R6", 6, 6,  21, 90, 0, 1, 0, 1, 1);
    t_ip("icmp R5",             5, 1,  30, 0,  1, 0, 0, 1, 1);
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule